// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the first byte that follows a bus START (or repeated START) is addressed to this device. It holds an own-address register that software loads through a simple write port. Bits 7..1 of the register carry the 7-bit device address, and bit 0 is a read/write bit. A mode input picks the comparison rule, and a single output flag reports a match.

The block has two addressing modes. In 7-bit mode it compares only the address bits and ignores the register's bit 0. In 10-bit mode it compares all eight bits, so the read/write bit takes part. A STOP condition clears the read/write bit on its own.

Only the first received byte after each START is examined. The flag then holds its value until the next START or STOP. The neighbouring shifter supplies START and STOP pulses and a byte-valid strobe with the byte.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_o is 0 and own_addr_o is 8'h00.
- R2: A cycle with cpu_we_i=1 loads cpu_wdata_i into the own-address register, and own_addr_o shows the new value on the next cycle. Bits 7..1 hold the device address and bit 0 holds the read/write bit.
- R3: When mode_10b_i=0 (7-bit mode), the first byte after START matches when byte_i[7:1] equals own_addr_o[7:1], whatever the value of byte_i[0] and own_addr_o[0].
- R4: When mode_10b_i=1 (10-bit mode), the first byte after START matches only when all 8 bits equal own_addr_o.
- R5: After the first byte following a START, further byte strobes leave match_o unchanged until the next START or STOP.
- R6: match_o rises on the clock edge that samples the first byte strobe after START, so it is visible one cycle after the strobe, and only when the comparison succeeds.
- R7: A start_i or stop_i pulse clears match_o on the next edge. A start_i in the same cycle as a byte strobe wins: that byte is not compared, and the following byte is treated as the first byte.
- R8: A stop_i pulse clears own_addr_o[0] and leaves bits 7..1 unchanged.
- R9: When cpu_we_i and stop_i are asserted in the same cycle, the written value is loaded unchanged, including bit 0.
- R10: Byte strobes that arrive after reset or after a STOP, with no START since then, never set match_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START / repeated START detected pulse |
| stop_i | input | 1 | STOP detected pulse |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | 8 | Received byte |
| mode_10b_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cpu_we_i | input | 1 | Own-address register write enable |
| cpu_wdata_i | input | 8 | Own-address register write data |
| own_addr_o | output | 8 | Current own-address register value |
| match_o | output | 1 | Address match flag |

## Verification
The assertions assume that start_i, stop_i and byte_vld_i are single-cycle pulses from a bus front end that is synchronous to clk_i. They also assume that mode_10b_i holds steady across a transfer. The bench drives every pulse for exactly one cycle on the falling edge and changes the mode only between transfers. The only overlaps it applies are the deliberate corner cases: a start with a strobe, and a write with a stop.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned ADDR_W_DEF = 7;
  localparam int unsigned REG_W_DEF  = ADDR_W_DEF + 1;
endpackage

// File: rtl/own_addr_reg.sv
module own_addr_reg #(
  parameter int unsigned REG_W = i2c_am_pkg::REG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             stop_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (we_i)   q <= wdata_i;          // write beats auto-clear
    else if (stop_i) q <= {q[REG_W-1:1], 1'b0};
  end

  assign q_o = q;

  // R2 R9
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));

  // R8
  rw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !we_i) |=> (!q_o[0] && q_o[REG_W-1:1] == $past(q_o[REG_W-1:1])));
endmodule

// File: rtl/first_byte_gate.sv
module first_byte_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_vld_i,
  output logic first_hit_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (start_i)     armed_q <= 1'b1;
    else if (stop_i)      armed_q <= 1'b0;
    else if (byte_vld_i)  armed_q <= 1'b0;
  end

  assign first_hit_o = armed_q && byte_vld_i && !start_i && !stop_i;

  // R5
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_hit_o && !start_i) |=> !first_hit_o);
endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
  parameter int unsigned REG_W = i2c_am_pkg::REG_W_DEF
) (
  input  logic [REG_W-1:0] own_i,
  input  logic [REG_W-1:0] rx_i,
  input  logic             mode_10b_i,
  output logic             eq_o
);
  logic [REG_W-1:0] bit_eq;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    assign bit_eq[i] = ~(own_i[i] ^ rx_i[i]);
  end

  // rw bit only counts in 10-bit mode
  assign eq_o = (&bit_eq[REG_W-1:1]) && (bit_eq[0] || !mode_10b_i);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned ADDR_W = i2c_am_pkg::ADDR_W_DEF,
  localparam int unsigned REG_W = ADDR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [REG_W-1:0] byte_i,
  input  logic             mode_10b_i,
  input  logic             cpu_we_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  output logic [REG_W-1:0] own_addr_o,
  output logic             match_o
);
  logic [REG_W-1:0] own_q;
  logic             first_hit;
  logic             eq;
  logic             match_q;

  own_addr_reg #(.REG_W(REG_W)) u_reg (
    .clk_i, .rst_ni,
    .we_i(cpu_we_i), .wdata_i(cpu_wdata_i), .stop_i,
    .q_o(own_q)
  );

  first_byte_gate u_gate (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_vld_i,
    .first_hit_o(first_hit)
  );

  addr_compare #(.REG_W(REG_W)) u_cmp (
    .own_i(own_q), .rx_i(byte_i), .mode_10b_i,
    .eq_o(eq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 match_q <= 1'b0;
    else if (start_i || stop_i)  match_q <= 1'b0;
    else if (first_hit)          match_q <= eq;
  end

  assign match_o    = match_q;
  assign own_addr_o = own_q;

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !match_o);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_hit && !start_i && !stop_i) |=> $stable(match_o));

  // R6
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(first_hit));
endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, vld = 1'b0, mode = 1'b0, we = 1'b0;
  logic [7:0] rx = '0, wdata = '0;
  logic [7:0] own;
  logic       match;
  int         tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  i2c_addr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(vld), .byte_i(rx), .mode_10b_i(mode),
    .cpu_we_i(we), .cpu_wdata_i(wdata),
    .own_addr_o(own), .match_o(match)
  );

  // {expected, mode, own, byte}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA0, 8'hA1},  // R3 rw ignored
    {1'b1, 1'b0, 8'hA0, 8'hA0},  // R3
    {1'b0, 1'b0, 8'hA0, 8'hA2},  // R3 addr bit differs
    {1'b1, 1'b1, 8'hA1, 8'hA1},  // R4
    {1'b0, 1'b1, 8'hA1, 8'hA0},  // R4 rw differs
    {1'b1, 1'b1, 8'h78, 8'h78},  // R4
    {1'b0, 1'b0, 8'hFE, 8'h7F},  // R3
    {1'b1, 1'b0, 8'h02, 8'h03}   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); vld = 1'b1; rx = b;
    @(negedge clk); vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 match", {7'd0, match}, 8'h00);
    chk("R1 own", own, 8'h00);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      mode = VEC[i][16];
      wr(VEC[i][15:8]);
      chk("R2 load", own, VEC[i][15:8]);
      pulse_start();
      chk("R7 start clear", {7'd0, match}, 8'h00);
      send(VEC[i][7:0]);
      chk(VEC[i][16] ? "R4 R6 vec" : "R3 R6 vec", {7'd0, match}, {7'd0, VEC[i][17]});
    end

    // R10: no start since stop
    mode = 1'b0;
    pulse_stop();
    wr(8'h40);
    send(8'h40);
    chk("R10 no start", {7'd0, match}, 8'h00);

    // R5: later bytes ignored
    pulse_start(); send(8'h40);
    chk("R6 first", {7'd0, match}, 8'h01);
    send(8'h00);
    chk("R5 hold 1", {7'd0, match}, 8'h01);
    pulse_start(); send(8'h00);
    chk("R6 miss", {7'd0, match}, 8'h00);
    send(8'h40);
    chk("R5 hold 0", {7'd0, match}, 8'h00);

    // R7 stop clears, R10 byte after stop
    pulse_start(); send(8'h40);
    pulse_stop();
    chk("R7 stop clear", {7'd0, match}, 8'h00);
    send(8'h40);
    chk("R10 after stop", {7'd0, match}, 8'h00);

    // R7 start with strobe in same cycle
    @(negedge clk); start = 1'b1; vld = 1'b1; rx = 8'h40;
    @(negedge clk); start = 1'b0; vld = 1'b0;
    chk("R7 start wins", {7'd0, match}, 8'h00);
    send(8'h40);
    chk("R7 rearm", {7'd0, match}, 8'h01);

    // R8 stop clears rw bit
    wr(8'h41);
    pulse_stop();
    chk("R8 rw clear", own, 8'h40);

    // R9 write beats stop
    @(negedge clk); we = 1'b1; wdata = 8'h43; stop = 1'b1;
    @(negedge clk); we = 1'b0; stop = 1'b0;
    chk("R9 write prio", own, 8'h43);

    // R4 with auto-cleared rw
    mode = 1'b1;
    wr(8'h79);
    pulse_stop();
    chk("R8 rw clear 10b", own, 8'h78);
    pulse_start(); send(8'h79);
    chk("R4 old rw", {7'd0, match}, 8'h00);
    pulse_start(); send(8'h78);
    chk("R4 cleared rw", {7'd0, match}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule